// File: doc/BRIEF.md
# Prescaled Reloading Wake-Up Timer

This block is a periodic timer that keeps running when the rest of a chip is asleep. It counts down through a 23-bit chain made of two stages. A 7-bit prescaler steps on every count tick. A 16-bit stage steps once for each full prescaler turn. When the whole chain is zero on a tick, the 16-bit stage reloads from a programmed value and a sticky event flag is set. The flag drives a wake-up request at all times. It drives an interrupt request only when that is enabled.

Count ticks come from one of two sources. The first is every cycle of the system clock. The second is each rising edge of a crystal clock input, seen through a two-flop synchronizer and an edge detector. A small byte-wide register port sets the reload value, the enable, the clock select and the interrupt enable. Through the same port software clears the flag and reads the live 16-bit count. Reading the low byte captures the high byte into a shadow register, so the two bytes of a read belong together. Only the power-on and watchdog reset inputs clear the block. Each is active low and asserts asynchronously. Their release is synchronized to the clock.

Register map:

| Address | Write | Read |
|---|---|---|
| 0 | control: bit0 enable, bit1 crystal select, bit2 interrupt enable, bit7 = 1 clears the flag | bit7 flag, bit2 interrupt enable, bit1 crystal select, bit0 enable, other bits 0 |
| 1 | reload value, low byte | live count, low byte; a read strobe here captures the high byte |
| 2 | reload value, high byte | captured high byte |
| 3 | no effect | 0x00 |

Top module: `wake_timer`

## Requirements
- R1: While `por_n` or `wdt_rst_n` is low, and for two rising edges after both are high, the block holds its reset state. Address 0 reads 0x00. Address 1 reads 0xFF. Address 2 reads 0xFF. The reload value is 0xFFFF, the prescaler is 127, and `irq` and `wake` are low. The third rising edge after release is the first active one.
- R2: Address 3 always reads 0x00. Writes to address 3 change nothing.
- R3: A write to address 0 with bit0 = 1 while the block is disabled loads the prescaler with 127 and the 16-bit count with the reload value. No counting happens in that cycle. Writing bit0 = 1 again while enabled does not reload.
- R4: When enabled with bit1 = 0, the prescaler decreases by one on every clock. When it steps from 0 to 127, the 16-bit count decreases by one.
- R5: A tick on which both stages are zero reloads the 16-bit count from the reload value, sets the prescaler to 127 and sets the flag. The period is (reload+1)*128 ticks: with reload 1, the flag reads 1 after the 256th edge that follows the enabling write.
- R6: The flag stays set until a write to address 0 with bit7 = 1. If a wrap happens in the same cycle as the clear, the flag stays set.
- R7: `wake` equals the flag. `irq` equals the flag AND the interrupt enable (bit2).
- R8: With bit1 = 1, one tick is made per rising edge of `xtal_clk`, after a two-flop synchronizer and an edge detector. While `xtal_clk` is still, the count does not move.
- R9: A read strobe (`rd_en`) at address 1 copies the current high byte of the count into the shadow, which address 2 returns.
- R10: Writes to addresses 1 and 2 set the low and high reload bytes. They affect the count only at the next load or wrap.
- R11: While disabled, the count and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| por_n | input | 1 | power-on reset, active low, asynchronous assert |
| wdt_rst_n | input | 1 | watchdog reset, active low, asynchronous assert |
| xtal_clk | input | 1 | crystal clock, sampled as data |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 2 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational from `addr` |
| irq | output | 1 | interrupt request |
| wake | output | 1 | wake-up request |

## Verification
Some rules are checked by assertions on every cycle. These are: the prescaler stepping down by one, the load on the enabling write, the hold while disabled, the reload and flag set at the wrap, the flag falling only on a clear write, the interrupt implying wake, and the shadow capture. The bench's scenarios are needed for the rest. They show the exact period measured in cycles, the latency of the crystal-tick path, the reset values after power-on and after a watchdog pulse, and that a second enable write does not reload. They also show that a still crystal clock freezes the count and that a reload write leaves a running count alone.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_LO   = 2'd1,
    ADR_HI   = 2'd2,
    ADR_NONE = 2'd3
  } wt_addr_e;

  // control register bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_XSEL = 1;
  localparam int unsigned CB_IE   = 2;
  localparam int unsigned CB_FLAG = 7;
endpackage

// File: rtl/wt_rst_sync.sv
module wt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sr_d = 1'b1;
    end else begin : g_many
      assign sr_d = {sr_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n = sr_q[STAGES-1];
endmodule

// File: rtl/wt_tick_gen.sv
module wt_tick_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_clk,
  input  logic sel_xtal,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = xtal_clk;
    end else begin : g_many
      assign sync_d = {sync_q[SYNC_STAGES-2:0], xtal_clk};
    end
  endgenerate

  assign prev_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (sel_xtal) tick = sync_q[SYNC_STAGES-1] & ~prev_q;
    else          tick = 1'b1;
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int unsigned PRE_W = 7,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [PRE_W-1:0] pre_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] pre_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load) begin
      pre_d = PRE_MAX;
      cnt_d = reload;
    end else if (en && tick) begin
      if (pre_q == '0) begin
        pre_d = PRE_MAX;
        if (cnt_q == '0) begin
          cnt_d = reload;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_MAX;
      cnt_q <= '1;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic [BYTE_W-1:0] rdata,
  output logic              en_q,
  output logic              xsel_q,
  output logic              ie_q,
  output logic              flag_q,
  output logic              load,
  output logic [CNT_W-1:0]  reload_q,
  output logic [BYTE_W-1:0] shadow_q
);
  localparam int unsigned HI_LSB = BYTE_W;

  logic en_d, xsel_d, ie_d, flag_d;
  logic [CNT_W-1:0]  reload_d;
  logic [BYTE_W-1:0] shadow_d;
  logic wr_ctrl, wr_lo, wr_hi, rd_lo;

  assign wr_ctrl = wr_en && (addr == ADR_CTRL);
  assign wr_lo   = wr_en && (addr == ADR_LO);
  assign wr_hi   = wr_en && (addr == ADR_HI);
  assign rd_lo   = rd_en && (addr == ADR_LO);
  assign load    = wr_ctrl && wdata[CB_EN] && !en_q;

  always_comb begin
    en_d     = en_q;
    xsel_d   = xsel_q;
    ie_d     = ie_q;
    flag_d   = flag_q;
    reload_d = reload_q;
    shadow_d = shadow_q;
    if (wr_ctrl) begin
      en_d   = wdata[CB_EN];
      xsel_d = wdata[CB_XSEL];
      ie_d   = wdata[CB_IE];
      if (wdata[CB_FLAG]) flag_d = 1'b0;
    end
    if (wrap) flag_d = 1'b1;
    if (wr_lo) reload_d[BYTE_W-1:0]     = wdata;
    if (wr_hi) reload_d[CNT_W-1:HI_LSB] = wdata;
    if (rd_lo) shadow_d = cnt[CNT_W-1:HI_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      xsel_q   <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      reload_q <= '1;
      shadow_q <= '1;
    end else begin
      en_q     <= en_d;
      xsel_q   <= xsel_d;
      ie_q     <= ie_d;
      flag_q   <= flag_d;
      reload_q <= reload_d;
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[CB_EN]   = en_q;
        rdata[CB_XSEL] = xsel_q;
        rdata[CB_IE]   = ie_q;
        rdata[CB_FLAG] = flag_q;
      end
      ADR_LO:  rdata = cnt[BYTE_W-1:0];
      ADR_HI:  rdata = shadow_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int unsigned PRE_W       = 7,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wdt_rst_n,
  input  logic              xtal_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  output logic              wake
);
  logic arst_n, rst_sync_n;
  logic tick, wrap, load;
  logic en_q, xsel_q, ie_q, flag_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q, reload_q;
  logic [BYTE_W-1:0] shadow_q;

  assign arst_n = por_n & wdt_rst_n;

  wt_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_sync_n)
  );

  wt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) i_tick (
    .clk(clk), .rst_n(rst_sync_n), .xtal_clk(xtal_clk),
    .sel_xtal(xsel_q), .tick(tick)
  );

  wt_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(en_q), .load(load), .tick(tick),
    .reload(reload_q), .pre_q(pre_q), .cnt_q(cnt_q), .wrap(wrap)
  );

  wt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cnt(cnt_q), .wrap(wrap), .rdata(rdata),
    .en_q(en_q), .xsel_q(xsel_q), .ie_q(ie_q), .flag_q(flag_q),
    .load(load), .reload_q(reload_q), .shadow_q(shadow_q)
  );

  assign wake = flag_q;
  assign irq  = flag_q & ie_q;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int unsigned PRE_W = 7,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic             clr_bit,
  input logic             en,
  input logic             tick,
  input logic             load,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [7:0]       shadow,
  input logic             irq,
  input logic             wake
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;
  localparam int unsigned      HI_LSB  = 8;

  AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pre == PRE_MAX) && (cnt == $past(reload)));  // R3

  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load && pre != '0) |=> (pre == $past(pre) - 1'b1) && $stable(cnt));  // R4

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load && pre == '0 && cnt == '0) |=> wake && (cnt == $past(reload)) && (pre == PRE_MAX));  // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake) |-> $past(wr_en && addr == 2'd0 && clr_bit));  // R6

  AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);  // R7

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |=> (shadow == $past(cnt[CNT_W-1:HI_LSB])));  // R9

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt) && $stable(pre));  // R11
endmodule

bind wake_timer wt_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .clr_bit(wdata[7]), .en(en_q), .tick(tick), .load(load), .pre(pre_q),
  .cnt(cnt_q), .reload(reload_q), .shadow(shadow_q), .irq(irq), .wake(wake)
);

// File: tb/test_wake_timer.sv
module test_wake_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n = 1'b0, wdt_rst_n = 1'b0, xtal_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq, wake;

  wake_timer i_wake_timer (
    .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .xtal_clk(xtal_clk),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wake(wake)
  );

  int total = 0, bad = 0, cycles = 0;

  // behavioural reference state
  int m_en = 0, m_xs = 0, m_ie = 0, m_flag = 0;
  int m_rel = 'hFFFF, m_pre = 127, m_cnt = 'hFFFF, m_sh = 'hFF;
  int rs = 0;
  int xq[$];
  int last_x = 0;

  task automatic model_reset();
    m_en = 0; m_xs = 0; m_ie = 0; m_flag = 0;
    m_rel = 'hFFFF; m_pre = 127; m_cnt = 'hFFFF; m_sh = 'hFF;
    xq = {0, 0}; last_x = 0;
  endtask

  always @(posedge clk) begin
    if (!por_n || !wdt_rst_n) begin
      rs = 0;
      model_reset();
    end else if (rs < 2) begin
      rs++;
      model_reset();
    end else begin
      int tk, ld, wr0;
      // crystal edge seen two samples late, then edge detected
      tk  = m_xs ? ((xq[0] == 1 && last_x == 0) ? 1 : 0) : 1;
      wr0 = (wr_en && addr == 2'd0) ? 1 : 0;
      ld  = (wr0 && wdata[0] && !m_en) ? 1 : 0;
      if (rd_en && addr == 2'd1) m_sh = m_cnt / 256;
      if (ld) begin
        m_pre = 127; m_cnt = m_rel;
      end else if (m_en && tk) begin
        if (m_pre == 0) begin
          m_pre = 127;
          if (m_cnt == 0) begin
            m_cnt = m_rel; m_flag = 2;
          end else m_cnt = m_cnt - 1;
        end else m_pre = m_pre - 1;
      end
      if (m_flag == 2) m_flag = 1;
      else if (wr0 && wdata[7]) m_flag = 0;
      if (wr0) begin
        m_en = wdata[0]; m_xs = wdata[1]; m_ie = wdata[2];
      end
      if (wr_en && addr == 2'd1) m_rel = (m_rel & 'hFF00) | wdata;
      if (wr_en && addr == 2'd2) m_rel = (m_rel & 'h00FF) | (wdata << 8);
      last_x = xq[0];
      void'(xq.pop_front());
      xq.push_back(int'(xtal_clk));
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_flag * 128 + m_ie * 4 + m_xs * 2 + m_en;
      2'd1: return m_cnt % 256;
      2'd2: return m_sh;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    string tag;
    case (addr)
      2'd0: tag = "R6 ctrl";
      2'd1: tag = "R4 count";
      2'd2: tag = "R9 shadow";
      default: tag = "R2 unused";
    endcase
    check(tag, 16'(rdata), 16'(exp_rd(addr)));
    check("R7 irq", 16'(irq), 16'(m_flag & m_ie));
    check("R7 wake", 16'(wake), 16'(m_flag));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic peek(string tag, logic [1:0] a, int exp);
    addr = a;
    #1;
    check(tag, 16'(rdata), 16'(exp));
  endtask

  task automatic strobe_lo();
    addr = 2'd1; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  // crystal clock source, period 10 system clocks when running
  logic xt_run = 1'b0;
  int xdiv = 0;
  always @(negedge clk) begin
    if (xt_run) begin
      xdiv++;
      if (xdiv == 5) begin
        xtal_clk = ~xtal_clk;
        xdiv = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    // R1: power-on reset
    run(3);
    por_n = 1'b1; wdt_rst_n = 1'b1;
    run(3);
    peek("R1 ctrl", 2'd0, 0);
    peek("R1 count lo", 2'd1, 'hFF);
    peek("R1 shadow", 2'd2, 'hFF);
    check("R1 wake", 16'(wake), 16'd0);
    check("R1 irq", 16'(irq), 16'd0);

    // R2: address 3 writes ignored, reads zero
    wr(2'd3, 8'hA5);
    peek("R2 addr3", 2'd3, 0);
    peek("R2 ctrl untouched", 2'd0, 0);
    peek("R2 count untouched", 2'd1, 'hFF);

    // R10/R5: reload 1 gives a 256-tick period
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    peek("R10 count before load", 2'd1, 'hFF);
    wr(2'd0, 8'h05);
    run(255);
    check("R5 no flag before period", 16'(wake), 16'd0);
    step();
    check("R5 flag at period", 16'(wake), 16'd1);
    check("R7 irq enabled", 16'(irq), 16'd1);
    peek("R5 reloaded count", 2'd1, 1);

    // R6: flag sticky, cleared by bit7
    wr(2'd0, 8'h05);
    check("R6 flag kept", 16'(wake), 16'd1);
    wr(2'd0, 8'h01);
    check("R7 irq gated", 16'(irq), 16'd0);
    check("R7 wake ungated", 16'(wake), 16'd1);
    wr(2'd0, 8'h85);
    check("R6 flag cleared", 16'(wake), 16'd0);

    // R11: disabled holds
    wr(2'd0, 8'h04);
    addr = 2'd1; #1; v = int'(rdata);
    run(300);
    peek("R11 hold", 2'd1, v);

    // R3/R9: load on enable, shadow capture
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h12);
    wr(2'd0, 8'h01);
    peek("R3 loaded lo", 2'd1, 'h34);
    strobe_lo();
    peek("R9 shadow hi", 2'd2, 'h12);
    run(200);
    wr(2'd0, 8'h01);
    peek("R3 no reload while running", 2'd1, exp_rd(2'd1));
    check("R3 count moved", 16'(m_cnt != 'h1234), 16'd1);
    run(400);

    // R8: crystal ticks
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h03);
    peek("R8 loaded", 2'd1, 'h34);
    run(300);
    peek("R8 still crystal holds", 2'd1, 'h34);
    xt_run = 1'b1;
    run(3000);
    peek("R8 crystal count", 2'd1, exp_rd(2'd1));
    check("R8 counted", 16'(m_cnt != 'h1234), 16'd1);
    xt_run = 1'b0;

    // R1: watchdog reset mid-run
    wdt_rst_n = 1'b0;
    step();
    wdt_rst_n = 1'b1;
    run(3);
    peek("R1 wdt ctrl", 2'd0, 0);
    peek("R1 wdt count", 2'd1, 'hFF);
    peek("R1 wdt shadow", 2'd2, 'hFF);
    check("R1 wdt wake", 16'(wake), 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule